// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block drives the hold and squash controls of an in-order pipeline with a configurable number of stages. Hazard logic elsewhere asks it, per stage, to stall everything up to and including that stage, or to flush everything up to and including that stage. The block spreads each request backward to every younger stage, because an older instruction cannot be held while a younger one behind it keeps moving. It also reports where the single bubble of a stall cycle enters the pipeline, and it holds the program counter whenever the fetch stage is held.

A conservative hazard mode can be enabled. It needs no register comparison: while the stage just past the first `FLUSH_K` stages holds a real instruction, all of the first `FLUSH_K` stages are squashed. `FLUSH_K` is the worst-case count of empty slots that dependent instructions need between them. A stage whose instruction has already changed architected state is never squashed. When both controls reach one stage, the squash wins. A small guard limits how long the fetch stage can stay held. When the limit is reached it turns the pending stall into a squash of the same stages for one cycle, so the pipeline always moves on.

Stages are numbered 0 (fetch) to `NUM_STAGES-1`. Every output except the guard's counter is combinational in the current inputs.

Top module: `pipe_hold_flush_ctl`

## Requirements
- R1: With no squash and no guard release, stage i is stalled exactly when `stall_upto_req[j]` is 1 for some j >= i.
- R2: `flush_upto_req[j]` = 1 squashes every stage i <= j, unless R5 masks that stage.
- R3: With `flushk_en` = 1 and `probe_busy` = 1, stages 0 to `FLUSH_K-1` are squashed. Stage `FLUSH_K` and all later stages are never squashed by this rule.
- R4: With two stages and `FLUSH_K` = 1, stage 0 is squashed whenever `flushk_en` and `probe_busy` are both 1.
- R5: A stage with `state_done[i]` = 1 never has `flush_o[i]` = 1, whatever the requests are.
- R6: A stage that is squashed is not stalled in the same cycle.
- R7: `pc_hold` is 1 exactly when `stall_o[0]` is 1.
- R8: `bubble_o[0]` is 0. For i >= 1, `bubble_o[i]` is 1 when stage i-1 is stalled and stage i is not. With no squash active, at most one bubble bit is set.
- R9: `stall_o[0]` is never high for more than `HOLD_LIMIT` consecutive cycles. On the release cycle all stall outputs are 0, and each stage that the stall requests would have held is squashed instead (subject to R5).
- R10: During and right after reset, with all request inputs 0, all outputs are 0. The consecutive-hold count starts from zero.
- R11: With `flushk_en` = 0, `probe_busy` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold-length guard |
| rst_n | input | 1 | Active-low reset of the guard counter |
| flushk_en | input | 1 | Enables the conservative occupancy squash rule |
| stall_upto_req | input | NUM_STAGES | Bit j asks to hold stages 0..j |
| flush_upto_req | input | NUM_STAGES | Bit j asks to squash stages 0..j |
| probe_busy | input | 1 | Stage FLUSH_K holds a non-empty instruction |
| state_done | input | NUM_STAGES | Bit i: stage i has already changed architected state |
| stall_o | output | NUM_STAGES | Per-stage hold |
| flush_o | output | NUM_STAGES | Per-stage squash |
| bubble_o | output | NUM_STAGES | Stage that receives the bubble of a stall |
| pc_hold | output | 1 | Keep the program counter unchanged |

## Verification
The bench builds two instances. The first has two stages, `FLUSH_K` = 1 and a hold limit of 3, which makes it small enough to apply every combination of its eight input bits. The second has four stages, `FLUSH_K` = 2 and a hold limit of 4. All 16384 combinations of its request, occupancy, mode and state-done inputs are applied, with an idle cycle between them so that the guard stays at rest. A separate directed run holds a stall request long enough to reach the guard release and its masked variant within a few cycles.

// File: rtl/pipe_hold_flush_pkg.sv
`timescale 1ns/1ps
package pipe_hold_flush_pkg;

  localparam int unsigned MAX_STAGES = 8;
  localparam int unsigned MIN_STAGES = 2;

  // width of a counter that must reach the value lim
  function automatic int unsigned count_width(int unsigned lim);
    int unsigned w;
    w = 1;
    while ((1 << w) <= lim) w++;
    return w;
  endfunction

endpackage

// File: rtl/phf_stall_chain.sv
`timescale 1ns/1ps
module phf_stall_chain #(
  parameter int unsigned NUM_STAGES = 4
) (
  input  logic [NUM_STAGES-1:0] stall_upto_req,
  input  logic                  guard_release,
  output logic [NUM_STAGES-1:0] stall_spread,
  output logic [NUM_STAGES-1:0] stall_keep,
  output logic [NUM_STAGES-1:0] stall_to_flush
);

  // each stage holds if it or any older stage ahead of it asks
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_chain
    if (g == NUM_STAGES - 1) begin : g_last
      assign stall_spread[g] = stall_upto_req[g];
    end else begin : g_mid
      assign stall_spread[g] = stall_upto_req[g] | stall_spread[g+1];
    end
  end

  // a guard release turns the hold into a squash of the same stages
  assign stall_keep     = guard_release ? '0 : stall_spread;
  assign stall_to_flush = guard_release ? stall_spread : '0;

endmodule

// File: rtl/phf_flush_gen.sv
`timescale 1ns/1ps
module phf_flush_gen #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned FLUSH_K    = 2
) (
  input  logic                  flushk_en,
  input  logic                  probe_busy,
  input  logic [NUM_STAGES-1:0] flush_upto_req,
  input  logic [NUM_STAGES-1:0] stall_to_flush,
  input  logic [NUM_STAGES-1:0] state_done,
  output logic [NUM_STAGES-1:0] occ_flush,
  output logic [NUM_STAGES-1:0] flush_want,
  output logic [NUM_STAGES-1:0] flush_o
);

  // stages below k are covered by the occupancy rule
  function automatic logic [NUM_STAGES-1:0] young_mask(int unsigned k);
    logic [NUM_STAGES-1:0] m;
    for (int i = 0; i < NUM_STAGES; i++) m[i] = (i < k);
    return m;
  endfunction

  localparam logic [NUM_STAGES-1:0] YOUNG = young_mask(FLUSH_K);

  logic [NUM_STAGES-1:0] flush_spread;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_chain
    if (g == NUM_STAGES - 1) begin : g_last
      assign flush_spread[g] = flush_upto_req[g];
    end else begin : g_mid
      assign flush_spread[g] = flush_upto_req[g] | flush_spread[g+1];
    end
  end

  assign occ_flush  = (flushk_en && probe_busy) ? YOUNG : '0;
  assign flush_want = occ_flush | flush_spread | stall_to_flush;
  // an instruction that already changed architected state survives
  assign flush_o    = flush_want & ~state_done;

endmodule

// File: rtl/phf_progress_guard.sv
`timescale 1ns/1ps
module phf_progress_guard
  import pipe_hold_flush_pkg::*;
#(
  parameter int unsigned HOLD_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_held,
  output logic guard_release
);

  localparam int unsigned CNT_W = count_width(HOLD_LIMIT);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(HOLD_LIMIT);

  logic [CNT_W-1:0] hold_cnt;

  assign guard_release = (hold_cnt == LIMIT_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (fetch_held && !guard_release) begin
      hold_cnt <= hold_cnt + 1'b1;
    end else begin
      hold_cnt <= '0;
    end
  end

endmodule

// File: rtl/pipe_hold_flush_ctl.sv
`timescale 1ns/1ps
module pipe_hold_flush_ctl #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned FLUSH_K    = 2,
  parameter int unsigned HOLD_LIMIT = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flushk_en,
  input  logic [NUM_STAGES-1:0] stall_upto_req,
  input  logic [NUM_STAGES-1:0] flush_upto_req,
  input  logic                  probe_busy,
  input  logic [NUM_STAGES-1:0] state_done,
  output logic [NUM_STAGES-1:0] stall_o,
  output logic [NUM_STAGES-1:0] flush_o,
  output logic [NUM_STAGES-1:0] bubble_o,
  output logic                  pc_hold
);

  logic [NUM_STAGES-1:0] stall_spread;
  logic [NUM_STAGES-1:0] stall_keep;
  logic [NUM_STAGES-1:0] stall_to_flush;
  logic [NUM_STAGES-1:0] occ_flush;
  logic [NUM_STAGES-1:0] flush_want;
  logic                  guard_release;
  logic                  fetch_held;

  phf_stall_chain #(.NUM_STAGES(NUM_STAGES)) u_stall (
    .stall_upto_req (stall_upto_req),
    .guard_release  (guard_release),
    .stall_spread   (stall_spread),
    .stall_keep     (stall_keep),
    .stall_to_flush (stall_to_flush)
  );

  phf_flush_gen #(.NUM_STAGES(NUM_STAGES), .FLUSH_K(FLUSH_K)) u_flush (
    .flushk_en      (flushk_en),
    .probe_busy     (probe_busy),
    .flush_upto_req (flush_upto_req),
    .stall_to_flush (stall_to_flush),
    .state_done     (state_done),
    .occ_flush      (occ_flush),
    .flush_want     (flush_want),
    .flush_o        (flush_o)
  );

  // squash wins over hold on a shared stage
  assign stall_o    = stall_keep & ~flush_o;
  assign fetch_held = stall_o[0];
  assign pc_hold    = fetch_held;

  phf_progress_guard #(.HOLD_LIMIT(HOLD_LIMIT)) u_guard (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_held    (fetch_held),
    .guard_release (guard_release)
  );

  // the bubble enters just after the oldest held stage
  assign bubble_o[0] = 1'b0;
  for (genvar g = 1; g < NUM_STAGES; g++) begin : g_bub
    assign bubble_o[g] = stall_o[g-1] & ~stall_o[g];
  end

endmodule

// File: rtl/pipe_hold_flush_ctl_chk.sv
`timescale 1ns/1ps
module pipe_hold_flush_ctl_chk
  import pipe_hold_flush_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned FLUSH_K    = 2,
  parameter int unsigned HOLD_LIMIT = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flushk_en,
  input logic                  probe_busy,
  input logic [NUM_STAGES-1:0] stall_upto_req,
  input logic [NUM_STAGES-1:0] state_done,
  input logic [NUM_STAGES-1:0] stall_o,
  input logic [NUM_STAGES-1:0] flush_o,
  input logic [NUM_STAGES-1:0] bubble_o,
  input logic                  pc_hold,
  input logic                  guard_release
);

  localparam int unsigned CW = count_width(HOLD_LIMIT + 1);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (stall_o[0]) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  AST_SQUASH_BEATS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o & stall_o) == '0); // R6
  AST_DONE_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o & state_done) == '0); // R5
  AST_PC_HOLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |-> (stall_upto_req != '0)); // R7
  AST_HOLD_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o == '0) |-> ((stall_o & (stall_o + 1'b1)) == '0)); // R1
  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o == '0) |-> ($countones(bubble_o) <= 1)); // R8
  AST_OCC_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    (flushk_en && probe_busy && !state_done[0]) |-> flush_o[0]); // R3
  AST_RELEASE_DROPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    guard_release |-> (stall_o == '0)); // R9
  AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= CW'(HOLD_LIMIT)); // R9

endmodule

bind pipe_hold_flush_ctl pipe_hold_flush_ctl_chk #(
  .NUM_STAGES(NUM_STAGES), .FLUSH_K(FLUSH_K), .HOLD_LIMIT(HOLD_LIMIT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .flushk_en      (flushk_en),
  .probe_busy     (probe_busy),
  .stall_upto_req (stall_upto_req),
  .state_done     (state_done),
  .stall_o        (stall_o),
  .flush_o        (flush_o),
  .bubble_o       (bubble_o),
  .pc_hold        (pc_hold),
  .guard_release  (guard_release)
);

// File: tb/pipe_hold_flush_ctl_tb.sv
`timescale 1ns/1ps
module pipe_hold_flush_ctl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  // four-stage instance
  logic       a_en = 0, a_busy = 0;
  logic [3:0] a_sreq = 0, a_freq = 0, a_done = 0;
  logic [3:0] a_st, a_fl, a_bub;
  logic       a_pc;

  pipe_hold_flush_ctl #(.NUM_STAGES(4), .FLUSH_K(2), .HOLD_LIMIT(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .flushk_en(a_en), .stall_upto_req(a_sreq),
    .flush_upto_req(a_freq), .probe_busy(a_busy), .state_done(a_done),
    .stall_o(a_st), .flush_o(a_fl), .bubble_o(a_bub), .pc_hold(a_pc));

  // two-stage instance
  logic       b_en = 0, b_busy = 0;
  logic [1:0] b_sreq = 0, b_freq = 0, b_done = 0;
  logic [1:0] b_st, b_fl, b_bub;
  logic       b_pc;

  pipe_hold_flush_ctl #(.NUM_STAGES(2), .FLUSH_K(1), .HOLD_LIMIT(3)) u_dut_two (
    .clk(clk), .rst_n(rst_n), .flushk_en(b_en), .stall_upto_req(b_sreq),
    .flush_upto_req(b_freq), .probe_busy(b_busy), .state_done(b_done),
    .stall_o(b_st), .flush_o(b_fl), .bubble_o(b_bub), .pc_hold(b_pc));

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // independent restatement of the requirements
  task automatic model(int n, int k, bit en, bit busy, bit [7:0] sreq,
                       bit [7:0] freq, bit [7:0] done, bit rel,
                       output bit [7:0] st, output bit [7:0] fl,
                       output bit [7:0] bub, output bit pc);
    st = '0; fl = '0; bub = '0;
    for (int i = 0; i < n; i++) begin
      bit s_any, f_any;
      s_any = |(sreq >> i);
      f_any = |(freq >> i);
      fl[i] = (f_any | (en & busy & (i < k)) | (rel & s_any)) & ~done[i];
      st[i] = s_any & ~rel & ~fl[i];
    end
    for (int i = 1; i < n; i++) bub[i] = st[i-1] & ~st[i];
    pc = st[0];
  endtask

  task automatic cmp_a(bit rel, string tag);
    bit [7:0] st, fl, bub; bit pc;
    model(4, 2, a_en, a_busy, 8'(a_sreq), 8'(a_freq), 8'(a_done), rel, st, fl, bub, pc);
    check({tag, " R1 stall"}, 8'(a_st), st);
    check({tag, " R2 R3 R5 flush"}, 8'(a_fl), fl);
    check({tag, " R8 bubble"}, 8'(a_bub), bub);
    check({tag, " R7 pc_hold"}, 8'(a_pc), 8'(pc));
  endtask

  task automatic cmp_b(string tag);
    bit [7:0] st, fl, bub; bit pc;
    model(2, 1, b_en, b_busy, 8'(b_sreq), 8'(b_freq), 8'(b_done), 1'b0, st, fl, bub, pc);
    check({tag, " R1 stall"}, 8'(b_st), st);
    check({tag, " R4 flush"}, 8'(b_fl), fl);
    check({tag, " R8 bubble"}, 8'(b_bub), bub);
    check({tag, " R7 pc_hold"}, 8'(b_pc), 8'(pc));
  endtask

  task automatic idle_all();
    a_en = 0; a_busy = 0; a_sreq = 0; a_freq = 0; a_done = 0;
    b_en = 0; b_busy = 0; b_sreq = 0; b_freq = 0; b_done = 0;
  endtask

  task automatic t_reset();
    idle_all();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset stall", 8'(a_st), 8'h0);
    check("R10 reset flush", 8'(a_fl), 8'h0);
    check("R10 reset pc", 8'(a_pc | b_pc), 8'h0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R10 after reset", {a_st, a_fl}, 8'h0);
  endtask

  task automatic t_sweep_two();
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      {b_en, b_busy, b_sreq, b_freq, b_done} = 8'(v);
      #1 cmp_b("sweep2");
      #2 idle_all();
    end
  endtask

  task automatic t_sweep_four();
    for (int v = 0; v < 16384; v++) begin
      @(negedge clk);
      {a_en, a_busy, a_sreq, a_freq, a_done} = 14'(v);
      #1 cmp_a(1'b0, "sweep4");
      #2 idle_all();
    end
  endtask

  task automatic t_directed();
    @(negedge clk);
    a_en = 1; a_busy = 1;
    #1 check("R3 stages 0,1 squashed, 2,3 not", 8'(a_fl), 8'b0011);
    a_sreq = 4'b1000;
    #1 check("R6 squash beats hold", 8'(a_st), 8'b1100);
    a_sreq = 0; a_en = 0;
    #1 check("R11 busy ignored when mode off", {a_st, a_fl}, 8'h0);
    a_freq = 4'b0100; a_done = 4'b0010;
    #1 check("R5 done stage kept", 8'(a_fl), 8'b0101);
    b_en = 1; b_busy = 1;
    #1 check("R4 two-stage squash", 8'(b_fl), 8'b01);
    #2 idle_all();
  endtask

  task automatic t_guard(logic [3:0] done_v, string tag);
    @(negedge clk);
    a_sreq = 4'b0100; a_done = done_v;
    for (int j = 0; j < 7; j++) begin
      if (j > 0) @(negedge clk);
      #1;
      if (j == 4) begin
        cmp_a(1'b1, {tag, " R9 release"});
        check({tag, " R9 release no hold"}, 8'(a_st), 8'h0);
      end else begin
        cmp_a(1'b0, {tag, " R9 held"});
        check({tag, " R9 held"}, 8'(a_st), 8'b0111);
      end
    end
    idle_all();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_sweep_two();
    t_sweep_four();
    t_directed();
    t_guard(4'b0000, "guard");
    t_guard(4'b0010, "guard masked");
    finish_run();
  end

  initial begin
    #1500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule